// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block steps a 16-bit processor core through the machine-cycle phases of each instruction. Execution always begins in CK1 and always finishes in CK4. A class code picks how many clocks the instruction takes: two, three or four. The final phase is the only one that can wait. When the instruction uses the operand bus, the block raises the data strobe during that phase and stays in it until the active-low transfer acknowledge arrives. A bus-error input or a memory-protect input can end the wait early.

The block also sequences stores and loads on the instruction port. When a port access starts, the block takes the accumulator value as the 20-bit port address and keeps it on the address bus from the first phase to the last. A store drives the data word for the whole instruction and pulses the write strobe after the first phase. A load captures the port data bus at the end of its last phase.

A one-cycle done signal marks the final cycle of every instruction. A two-bit error code keeps the first bus fault seen until reset. The core issues a start pulse, then waits for done before issuing the next one.

Top module: `bcyc_seq`

## Requirements
- R1: While in reset or idle, the block drives these outputs low or zero: all phase strobes, STATE1, DS, WE, the RD drive enable, RD, RA and done. A reset also clears the error code to 2'b00 and the load register to zero.
- R2: The phase strobes are one-hot: bit 0 is CK1 and bit 3 is CK4. Class code 2'd0 runs CK1 then CK4. Code 2'd1 runs CK1, CK2, CK4. Codes 2'd2 and 2'd3 run CK1, CK2, CK3, CK4. CK1 starts in the cycle after the clock edge that samples start.
- R3: STATE1 is high in every cycle of an instruction, including every stretched CK4 cycle, and low between instructions.
- R4: DS is high only during CK4, and only for an instruction started with the operand flag set.
- R5: When DS is high, CK4 repeats on every clock edge that samples the acknowledge high with no fault input active. An edge that samples the acknowledge low ends CK4. Without the operand flag, CK4 lasts exactly one cycle.
- R6: When DS is high, a bus error or a memory protect ends CK4 at once. If the error code is 2'b00, it becomes 2'b01 for a bus error or 2'b10 for memory protect, and bus error wins when both are active. Once nonzero, the code holds until reset. Fault inputs have no effect outside DS.
- R7: Done is high for exactly one cycle: the final CK4 cycle of each instruction.
- R8: A start is accepted only in idle. A start held high during an instruction neither restarts it nor queues another one.
- R9: On a store (write flag set), RA carries the accumulator value latched at start for every phase. RD is driven with the store word in every phase. WE is high in every phase after CK1. WE stays low in all other instructions. If both port flags are set, the instruction is a store.
- R10: On a load (read flag set, write flag clear), RA carries the latched accumulator value, and the RD input is captured into the load register on the edge that ends CK4. A fault ending leaves the load register unchanged. When neither port flag is set, RA is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction start request |
| cls_i | input | 2 | Clock-count class: 0 two, 1 three, 2 or 3 four |
| opnd_i | input | 1 | Instruction uses the operand bus |
| iwr_i | input | 1 | Instruction-port store |
| ird_i | input | 1 | Instruction-port load |
| acc_addr_i | input | 20 | Accumulator value used as port address |
| st_data_i | input | 16 | Word to store on the instruction port |
| rd_i | input | 16 | Instruction-port data bus input |
| dtack_n_i | input | 1 | Transfer acknowledge, active low |
| bus_err_i | input | 1 | Bus error |
| mem_prot_i | input | 1 | Memory protect violation |
| ck_o | output | 4 | One-hot phase strobes, bit 0 is CK1 |
| state1_o | output | 1 | Instruction executing |
| ds_o | output | 1 | Operand data strobe |
| we_o | output | 1 | Instruction-port write enable |
| ra_o | output | 20 | Instruction-port address bus |
| rd_o | output | 16 | Instruction-port data drive value |
| rd_oe_o | output | 1 | Instruction-port data drive enable |
| ld_data_o | output | 16 | Last word loaded from the instruction port |
| done_o | output | 1 | Final cycle of an instruction |
| err_o | output | 2 | Sticky error code |

## Verification
The bench runs operand accesses whose acknowledge arrives at once and after several cycles. A design that skipped or miscounted the stretch would give done too early or too late, and the monitor would report the instruction length as wrong. It ends stretches with each fault input alone, with both faults together, and with a fault that follows an earlier one. A design with the wrong priority, a code that does not stick, or a load captured on a fault would show a wrong error code or a changed load word. It also holds start high through a busy instruction, asserts faults on an instruction that has no operand access, and sets both port flags at once. A design that accepted starts while busy, reacted to faults outside DS, or let a load beat a store would show an extra instruction, a spurious code or a missing WE.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

  localparam int NUM_PH = 4;
  localparam int PH_W   = 3;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE = 3'd0,
    PH_CK1  = 3'd1,
    PH_CK2  = 3'd2,
    PH_CK3  = 3'd3,
    PH_CK4  = 3'd4
  } phase_e;

  localparam logic [1:0] CLS_TWO   = 2'd0;
  localparam logic [1:0] CLS_THREE = 2'd1;

  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_BUS  = 2'b01;
  localparam logic [1:0] ERR_PROT = 2'b10;

  typedef struct packed {
    logic       opnd;
    logic       store;
    logic       load;
    logic [1:0] cls;
  } instr_t;

endpackage

// File: rtl/bcyc_rst_sync.sv
module bcyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  // Assert asynchronously, release through the flop chain
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bcyc_phase_fsm.sv
module bcyc_phase_fsm
  import bcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] cls_i,
  input  logic       opnd_i,
  input  logic       iwr_i,
  input  logic       ird_i,
  input  logic       dtack_n_i,
  input  logic       bus_err_i,
  input  logic       mem_prot_i,
  output phase_e     phase_o,
  output instr_t     instr_o,
  output logic       accept_o,
  output logic       last_o
);

  phase_e ph_q, ph_d;
  instr_t ins_q, ins_d;
  logic   accept;
  logic   last;

  always_comb begin
    accept = (ph_q == PH_IDLE) && start_i;
    // final CK4 cycle: no wait needed, acknowledge seen, or a fault ends it
    last   = (ph_q == PH_CK4) &&
             (!ins_q.opnd || !dtack_n_i || bus_err_i || mem_prot_i);

    ins_d.opnd  = opnd_i;
    ins_d.store = iwr_i;
    ins_d.load  = ird_i & ~iwr_i;
    ins_d.cls   = cls_i;
  end

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (accept) ph_d = PH_CK1;
      PH_CK1:  ph_d = (ins_q.cls == CLS_TWO)   ? PH_CK4 : PH_CK2;
      PH_CK2:  ph_d = (ins_q.cls == CLS_THREE) ? PH_CK4 : PH_CK3;
      PH_CK3:  ph_d = PH_CK4;
      PH_CK4:  if (last) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ins_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) ins_q <= ins_d;
    end
  end

  assign phase_o  = ph_q;
  assign instr_o  = ins_q;
  assign accept_o = accept;
  assign last_o   = last;

endmodule

// File: rtl/bcyc_err_trk.sv
module bcyc_err_trk
  import bcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       last_i,
  input  logic       opnd_i,
  input  logic       bus_err_i,
  input  logic       mem_prot_i,
  output logic       abort_o,
  output logic [1:0] err_o
);

  logic [1:0] err_q, code_d;
  logic       abort;
  logic       set_en;

  always_comb begin
    abort  = last_i && opnd_i && (bus_err_i || mem_prot_i);
    code_d = bus_err_i ? ERR_BUS : ERR_PROT;
    set_en = abort && (err_q == ERR_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= ERR_NONE;
    else if (set_en) err_q <= code_d;
  end

  assign abort_o = abort;
  assign err_o   = err_q;

endmodule

// File: rtl/bcyc_port_drv.sv
module bcyc_port_drv
  import bcyc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  phase_e        phase_i,
  input  logic          opnd_i,
  input  logic          store_i,
  input  logic          load_i,
  input  logic          last_i,
  input  logic          abort_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] rd_i,
  output logic [AW-1:0] ra_o,
  output logic [DW-1:0] rd_o,
  output logic          rd_oe_o,
  output logic          we_o,
  output logic          ds_o,
  output logic [DW-1:0] ld_data_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, ld_q;
  logic          busy, port_op, ld_en;

  always_comb begin
    busy    = (phase_i != PH_IDLE);
    port_op = store_i | load_i;
    ld_en   = last_i && load_i && !abort_i;
    ra_o    = (busy && port_op) ? addr_q : '0;
    rd_oe_o = busy && store_i;
    rd_o    = rd_oe_o ? data_q : '0;
    we_o    = busy && store_i && (phase_i != PH_CK1);
    ds_o    = (phase_i == PH_CK4) && opnd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept_i) begin
      addr_q <= acc_addr_i;
      data_q <= st_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ld_q <= '0;
    else if (ld_en) ld_q <= rd_i;
  end

  assign ld_data_o = ld_q;

endmodule

// File: rtl/bcyc_seq.sv
module bcyc_seq
  import bcyc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    cls_i,
  input  logic          opnd_i,
  input  logic          iwr_i,
  input  logic          ird_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [DW-1:0] rd_i,
  input  logic          dtack_n_i,
  input  logic          bus_err_i,
  input  logic          mem_prot_i,
  output logic [NUM_PH-1:0] ck_o,
  output logic          state1_o,
  output logic          ds_o,
  output logic          we_o,
  output logic [AW-1:0] ra_o,
  output logic [DW-1:0] rd_o,
  output logic          rd_oe_o,
  output logic [DW-1:0] ld_data_o,
  output logic          done_o,
  output logic [1:0]    err_o
);

  logic   rst_sync_n;
  phase_e phase;
  instr_t instr;
  logic   accept, last, abort;

  bcyc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  bcyc_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .cls_i      (cls_i),
    .opnd_i     (opnd_i),
    .iwr_i      (iwr_i),
    .ird_i      (ird_i),
    .dtack_n_i  (dtack_n_i),
    .bus_err_i  (bus_err_i),
    .mem_prot_i (mem_prot_i),
    .phase_o    (phase),
    .instr_o    (instr),
    .accept_o   (accept),
    .last_o     (last)
  );

  bcyc_err_trk u_err (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .last_i     (last),
    .opnd_i     (instr.opnd),
    .bus_err_i  (bus_err_i),
    .mem_prot_i (mem_prot_i),
    .abort_o    (abort),
    .err_o      (err_o)
  );

  bcyc_port_drv #(.AW(AW), .DW(DW)) u_port (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept_i   (accept),
    .phase_i    (phase),
    .opnd_i     (instr.opnd),
    .store_i    (instr.store),
    .load_i     (instr.load),
    .last_i     (last),
    .abort_i    (abort),
    .acc_addr_i (acc_addr_i),
    .st_data_i  (st_data_i),
    .rd_i       (rd_i),
    .ra_o       (ra_o),
    .rd_o       (rd_o),
    .rd_oe_o    (rd_oe_o),
    .we_o       (we_o),
    .ds_o       (ds_o),
    .ld_data_o  (ld_data_o)
  );

  // one strobe per phase, phase code g+1 lights bit g
  for (genvar g = 0; g < NUM_PH; g++) begin : g_strobe
    assign ck_o[g] = (phase == phase_e'(3'(g + 1)));
  end

  assign state1_o = (phase != PH_IDLE);
  assign done_o   = last;

endmodule

// File: rtl/bcyc_seq_chk.sv
module bcyc_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ck_o,
  input logic          state1_o,
  input logic          ds_o,
  input logic          we_o,
  input logic          rd_oe_o,
  input logic [AW-1:0] ra_o,
  input logic          done_o,
  input logic [1:0]    err_o,
  input logic          dtack_n_i,
  input logic          bus_err_i,
  input logic          mem_prot_i
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !state1_o |-> (!ds_o && !we_o && !rd_oe_o && !done_o && ra_o == '0));

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ck_o) == (state1_o ? 1 : 0));

  a_r2_ck1_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state1_o) |-> ck_o[0]);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state1_o && !done_o) |=> state1_o);

  a_r4_ds_only_ck4: assert property (@(posedge clk) disable iff (!rst_n)
    ds_o |-> ck_o[3]);

  a_r5_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_o && dtack_n_i && !bus_err_i && !mem_prot_i) |=> (ds_o && ck_o[3]));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != 2'b00) |=> $stable(err_o));

  a_r6_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_o && bus_err_i && err_o == 2'b00) |=> (err_o == 2'b01));

  a_r7_done_in_ck4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ck_o[3]);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state1_o && !ck_o[3]) |=> !ck_o[0]);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !state1_o);

  a_r9_we_window: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (rd_oe_o && !ck_o[0]));

endmodule

bind bcyc_seq bcyc_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ck_o       (ck_o),
  .state1_o   (state1_o),
  .ds_o       (ds_o),
  .we_o       (we_o),
  .rd_oe_o    (rd_oe_o),
  .ra_o       (ra_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .dtack_n_i  (dtack_n_i),
  .bus_err_i  (bus_err_i),
  .mem_prot_i (mem_prot_i)
);

// File: tb/bcyc_seq_bench.sv
`timescale 1ns/1ps
module bcyc_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  cls;
  logic        opnd, iwr, ird;
  logic [19:0] acc;
  logic [15:0] sdat, rdin;
  logic        dtack_n, berr, mprot;
  logic [3:0]  ck;
  logic        state1, ds, we, rd_oe, done;
  logic [19:0] ra;
  logic [15:0] rd_out, ld;
  logic [1:0]  err;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    int          clocks;
    logic [1:0]  err;
    logic [15:0] ld;
  } exp_t;
  exp_t sb_q[$];

  logic [1:0]  err_model;
  logic [15:0] ld_model;

  always #5 clk = ~clk;

  bcyc_seq u_bcyc_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cls_i(cls),
    .opnd_i(opnd), .iwr_i(iwr), .ird_i(ird), .acc_addr_i(acc),
    .st_data_i(sdat), .rd_i(rdin), .dtack_n_i(dtack_n),
    .bus_err_i(berr), .mem_prot_i(mprot), .ck_o(ck),
    .state1_o(state1), .ds_o(ds), .we_o(we), .ra_o(ra),
    .rd_o(rd_out), .rd_oe_o(rd_oe), .ld_data_o(ld),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int base_clocks(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 3 : 4;
  endfunction

  function automatic logic [3:0] exp_ck(input logic [1:0] c, input int idx);
    if (idx >= base_clocks(c) - 1) return 4'b1000;
    return 4'b0001 << idx;
  endfunction

  // monitor: counts busy cycles and compares against the scoreboard at done
  int   busy_cnt = 0;
  bit   pend = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (!rst_n) begin
      busy_cnt = 0;
      pend = 0;
    end else begin
      if (pend) begin
        chk(err == cur.err, "R6 error code", 32'(err), 32'(cur.err));
        chk(ld == cur.ld, "R10 load word", 32'(ld), 32'(cur.ld));
        pend = 0;
      end
      if (state1) busy_cnt++;
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7 unexpected done", 32'd1, 32'd0);
        end else begin
          cur = sb_q.pop_front();
          chk(busy_cnt == cur.clocks, "R5 instruction length",
              32'(busy_cnt), 32'(cur.clocks));
          pend = 1;
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic idle_inputs();
    start = 0; cls = 0; opnd = 0; iwr = 0; ird = 0;
    acc = '0; sdat = '0; rdin = '0;
    dtack_n = 1; berr = 0; mprot = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0;
    idle_inputs();
    @(negedge clk);
    chk(!state1 && ck == 4'b0 && !ds && !we && !rd_oe && !done && ra == '0,
        "R1 reset outputs", {ck, state1, ds, we, rd_oe, done}, 32'd0);
    chk(err == 2'b00 && ld == 16'h0, "R1 reset state", {err, ld}, 32'd0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    err_model = 2'b00;
    ld_model  = 16'h0;
  endtask

  // endmode: 0 acknowledge, 1 bus error, 2 protect, 3 both faults
  task automatic run(input logic [1:0] c, input bit op, input bit wr, input bit rdf,
                     input logic [19:0] a, input logic [15:0] d, input logic [15:0] rv,
                     input int wait_n, input int endmode, input bit inject);
    int   base, exp_clk, idx;
    bit   aborted, noise;
    exp_t e;
    base    = base_clocks(c);
    exp_clk = base + (op ? wait_n : 0);
    aborted = op && (endmode != 0);
    noise   = !op && (endmode != 0);
    if (aborted && err_model == 2'b00) err_model = (endmode == 2) ? 2'b10 : 2'b01;
    if (rdf && !wr && !aborted) ld_model = rv;
    e.clocks = exp_clk; e.err = err_model; e.ld = ld_model;
    sb_q.push_back(e);

    @(posedge clk); #1;
    start = 1; cls = c; opnd = op; iwr = wr; ird = rdf;
    acc = a; sdat = d; rdin = rv;
    berr = noise; mprot = noise; dtack_n = 1;
    @(posedge clk); #1;
    start = inject;
    cls = 2'd0; acc = ~a; sdat = ~d;   // altered after start: must not matter
    idx = 0;
    while (state1 && idx < 200) begin
      if (op) begin
        if (idx >= base - 1 && idx - (base - 1) == wait_n) begin
          dtack_n = !(endmode == 0);
          berr    = (endmode == 1) || (endmode == 3);
          mprot   = (endmode == 2) || (endmode == 3);
        end else begin
          dtack_n = 1; berr = 0; mprot = 0;
        end
      end
      @(negedge clk);
      chk(ck == exp_ck(c, idx), "R2 phase strobe", 32'(ck), 32'(exp_ck(c, idx)));
      chk(state1, "R3 state1 busy", 32'(state1), 32'd1);
      chk(ds == (op && idx >= base - 1), "R4 data strobe", 32'(ds),
          32'(op && idx >= base - 1));
      chk(done == (idx == exp_clk - 1), "R7 done timing", 32'(done),
          32'(idx == exp_clk - 1));
      if (wr || rdf)
        chk(ra == a, wr ? "R9 store address" : "R10 load address", 32'(ra), 32'(a));
      else
        chk(ra == '0, "R10 no port address", 32'(ra), 32'd0);
      chk(we == (wr && idx != 0), "R9 write strobe", 32'(we), 32'(wr && idx != 0));
      chk(rd_oe == wr, "R9 data drive", 32'(rd_oe), 32'(wr));
      if (wr) chk(rd_out == d, "R9 store data", 32'(rd_out), 32'(d));
      @(posedge clk); #1;
      idx++;
    end
    idle_inputs();
    chk(idx == exp_clk, "R5 busy cycles", 32'(idx), 32'(exp_clk));
    @(negedge clk);
    chk(!state1, "R8 no extra instruction", 32'(state1), 32'd0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    err_model = 2'b00;
    ld_model  = 16'h0;
    do_reset();
    // R2 plain classes
    run(2'd0, 0, 0, 0, 20'h0, 16'h0, 16'h0, 0, 0, 0);
    run(2'd1, 0, 0, 0, 20'h0, 16'h0, 16'h0, 0, 0, 0);
    run(2'd2, 0, 0, 0, 20'h0, 16'h0, 16'h0, 0, 0, 0);
    run(2'd3, 0, 0, 0, 20'h0, 16'h0, 16'h0, 0, 0, 0);
    // R5 acknowledge immediately and after waits
    run(2'd0, 1, 0, 0, 20'h0, 16'h0, 16'h0, 0, 0, 0);
    run(2'd2, 1, 0, 0, 20'h0, 16'h0, 16'h0, 3, 0, 0);
    // R6 faults ignored without operand access
    run(2'd1, 0, 0, 0, 20'h0, 16'h0, 16'h0, 0, 1, 0);
    // R9 store, R10 load
    run(2'd1, 0, 1, 0, 20'hA5A5A, 16'h1234, 16'h0, 0, 0, 0);
    run(2'd2, 0, 0, 1, 20'h12345, 16'h0, 16'hBEEF, 0, 0, 0);
    run(2'd0, 0, 1, 1, 20'h0F0F0, 16'h5A5A, 16'hDEAD, 0, 0, 0);
    run(2'd1, 1, 0, 1, 20'h00777, 16'h0, 16'hC0DE, 2, 0, 0);
    // R6 bus error with a load: no capture, then protect does not overwrite
    run(2'd2, 1, 0, 1, 20'h33333, 16'h0, 16'h1111, 2, 1, 0);
    run(2'd0, 1, 0, 0, 20'h0, 16'h0, 16'h0, 1, 2, 0);
    run(2'd1, 1, 0, 0, 20'h0, 16'h0, 16'h0, 0, 0, 0);
    // R8 start held high while busy
    run(2'd3, 1, 0, 0, 20'h0, 16'h0, 16'h0, 2, 0, 1);
    // R6 protect alone after reset, then both together
    do_reset();
    run(2'd1, 1, 0, 0, 20'h0, 16'h0, 16'h0, 1, 2, 0);
    do_reset();
    run(2'd2, 1, 0, 0, 20'h0, 16'h0, 16'h0, 4, 3, 0);
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R7 every instruction done", 32'(sb_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule